// File: doc/BRIEF.md
# Masked Pattern Timestamping Input Stage

This block watches one group of 16 logic inputs, sampled on a 100 MHz clock. It turns changes on those inputs into timestamped 16-bit pattern items. Each input first goes through its own enable gate and its own polarity flip. After that, only a rising edge of the conditioned signal counts as an event. A mode word chooses how events become items:

- **Free transition.** Every input that went high since the last clock is reported. As an option, the whole group can be qualified by a gate line.
- **Gated window.** Everything seen during a gate window is collected into one pattern. That pattern carries the time at which the window opened.
- **Coincidence.** Each rising overlap of this group with a second 16-bit group is reported. The first group can optionally be stretched to a programmable length.

Items leave on a valid/ready pair, together with the 48-bit counter value that was captured for them. An item that is not yet accepted stays on the outputs. Further hits that arrive meanwhile are ORed into its pattern, and its original timestamp is kept.

Top module: `pts_stage`

## Requirements
- R1: Input n contributes to an item only when bit n of `cfg_enable` is 1. A disabled input never appears in `out_pattern`.
- R2: When bit n of `cfg_invert` is 1, input n is inverted before edge detection. An item then follows a 1-to-0 change on the raw pin, and a 0-to-1 change on that pin produces nothing.
- R3: In free transition mode (`cfg_mode` bit 0), an input change sampled at clock edge k gives `out_valid` high after edge k+1. The pattern marks the inputs that rose, and `out_stamp` equals the `ts_in` value present just before edge k+1. An input that stays high gives no further item.
- R4: In free transition mode with `cfg_free_gate`=1, inputs are ANDed with `gate_in` before edge detection. A high input gives no item while the gate is low, and gives an item when the gate rises.
- R5: In gated mode (`cfg_mode` bit 1), the stamp is `ts_in` in the cycle after the gate's leading edge is sampled. The pattern is the OR of every enabled input level seen while the gate was high. The item appears only after the gate's falling edge, two clock edges after the low gate is sampled.
- R6: In coincidence mode (`cfg_mode` bit 2), an item appears when a bit of the conditioned group A and the same bit of `grp_b_in` become true together. The stamp rule is the one in R3.
- R7: Every separate coincidence makes its own item. Two B pulses that both overlap one stretched A pulse give two items.
- R8: With `cfg_mode` bit 3 set in coincidence mode, and `cfg_stretch`=S>0, an A rising edge holds that A bit high for exactly S*5 cycles from the edge. A new rising edge restarts the count.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_stamp` stay unchanged. New hits are ORed into `out_pattern`. The item clears on the edge where `out_ready`=1.
- R10: Mode bits have a fixed priority: coincidence (bit 2) over gated (bit 1) over free (bit 0). With bits 2:0 all zero, no item is produced.
- R11: During reset, and right after it, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_a_in | input | 16 | Group A raw inputs |
| grp_b_in | input | 16 | Group B inputs, already conditioned, used in coincidence mode |
| gate_in | input | 1 | Group gate |
| ts_in | input | 48 | Running timestamp counter value |
| cfg_enable | input | 16 | Per-input enable mask |
| cfg_invert | input | 16 | Per-input polarity flip |
| cfg_mode | input | 4 | Mode bits: 0 free, 1 gated, 2 coincidence, 3 stretch |
| cfg_stretch | input | 4 | Stretch length in 5-cycle steps |
| cfg_free_gate | input | 1 | AND the group with the gate in free mode |
| out_ready | input | 1 | Consumer accepts the item |
| out_valid | output | 1 | Item pending |
| out_pattern | output | 16 | Item pattern |
| out_stamp | output | 48 | Item timestamp |

## Verification
The hardest case to reach is the edge of the stretch window. A B pulse must land in exactly the last stretched cycle, or in the cycle just after it, and a second A edge must restart the count part way through. The stretch task drives A and B from one cycle-indexed loop, so each pulse lands in a chosen cycle counted from the A edge. With `out_ready` held high, each item shows for one cycle, and the task counts the items.

// File: rtl/pts_pkg.sv
`timescale 1ns/1ps
package pts_pkg;
  localparam int STEP_CYC = 5;

  typedef enum logic [1:0] {SEL_NONE, SEL_FREE, SEL_GATED, SEL_COIN} sel_e;

  // coincidence beats gated beats free
  function automatic sel_e pick_mode(input logic [3:0] m);
    if (m[2])      return SEL_COIN;
    else if (m[1]) return SEL_GATED;
    else if (m[0]) return SEL_FREE;
    else           return SEL_NONE;
  endfunction

  // number of cycles a stretched pulse lasts
  function automatic int unsigned stretch_cycles(input logic [3:0] s, input int unsigned step);
    return int'(s) * step;
  endfunction
endpackage

// File: rtl/pts_cond.sv
`timescale 1ns/1ps
module pts_cond #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] en,
  input  logic [W-1:0] inv,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl  <= '0;
      prev <= '0;
    end else begin
      lvl  <= (raw ^ inv) & en;
      prev <= lvl;
    end
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/pts_stretch.sv
`timescale 1ns/1ps
module pts_stretch
  import pts_pkg::*;
#(
  parameter int W    = 16,
  parameter int SW   = 4,
  parameter int STEP = STEP_CYC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on,
  input  logic [SW-1:0] sel,
  input  logic [W-1:0]  lvl,
  input  logic [W-1:0]  rise,
  output logic [W-1:0]  str
);
  localparam int MAXLEN = ((1 << SW) - 1) * STEP;
  localparam int CW     = $clog2(MAXLEN + 1);

  logic [CW-1:0] len;
  assign len = CW'(stretch_cycles(sel, STEP));

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt <= '0;
      else if (on && rise[i] && len != '0)
        cnt <= len - 1'b1;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
    assign str[i] = on ? (lvl[i] | (cnt != '0)) : lvl[i];
  end
endmodule

// File: rtl/pts_hold.sv
`timescale 1ns/1ps
module pts_hold #(
  parameter int W  = 16,
  parameter int TW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic [W-1:0]  pat_in,
  input  logic [TW-1:0] stamp_in,
  input  logic          ready,
  output logic          valid,
  output logic [W-1:0]  pat,
  output logic [TW-1:0] stamp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      pat   <= '0;
      stamp <= '0;
    end else if (!valid || ready) begin
      valid <= evt;
      if (evt) begin
        pat   <= pat_in;
        stamp <= stamp_in;
      end
    end else if (evt) begin
      pat <= pat | pat_in;
    end
  end
endmodule

// File: rtl/pts_stage.sv
`timescale 1ns/1ps
module pts_stage
  import pts_pkg::*;
#(
  parameter int W  = 16,
  parameter int TW = 48,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  grp_a_in,
  input  logic [W-1:0]  grp_b_in,
  input  logic          gate_in,
  input  logic [TW-1:0] ts_in,
  input  logic [W-1:0]  cfg_enable,
  input  logic [W-1:0]  cfg_invert,
  input  logic [3:0]    cfg_mode,
  input  logic [SW-1:0] cfg_stretch,
  input  logic          cfg_free_gate,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_pattern,
  output logic [TW-1:0] out_stamp
);
  sel_e          sel;
  logic [W-1:0]  lvl_a, rise_a, str_a;
  logic [W-1:0]  b_q, eff, eff_prev, coin, coin_prev;
  logic          gate_q, gate_prev;
  logic [W-1:0]  acc;
  logic [TW-1:0] acc_stamp;

  // named internal events
  logic [W-1:0]  free_hit, coin_hit;
  logic          gate_rise, gate_fall;
  logic          item_evt;
  logic [W-1:0]  item_pat;
  logic [TW-1:0] item_stamp;

  assign sel = pick_mode(cfg_mode);

  pts_cond #(.W(W)) u_cond (
    .clk(clk), .rst_n(rst_n), .raw(grp_a_in), .en(cfg_enable),
    .inv(cfg_invert), .lvl(lvl_a), .rise(rise_a)
  );

  pts_stretch #(.W(W), .SW(SW), .STEP(STEP_CYC)) u_str (
    .clk(clk), .rst_n(rst_n), .on(cfg_mode[3]), .sel(cfg_stretch),
    .lvl(lvl_a), .rise(rise_a), .str(str_a)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_q       <= '0;
      gate_q    <= 1'b0;
      gate_prev <= 1'b0;
      eff_prev  <= '0;
      coin_prev <= '0;
      acc       <= '0;
      acc_stamp <= '0;
    end else begin
      b_q       <= grp_b_in;
      gate_q    <= gate_in;
      gate_prev <= gate_q;
      eff_prev  <= eff;
      coin_prev <= coin;
      if (gate_rise) begin
        acc       <= lvl_a;
        acc_stamp <= ts_in;
      end else if (gate_q) begin
        acc <= acc | lvl_a;
      end
    end
  end

  assign eff       = lvl_a & (cfg_free_gate ? {W{gate_q}} : {W{1'b1}});
  assign free_hit  = eff & ~eff_prev;
  assign coin      = str_a & b_q;
  assign coin_hit  = coin & ~coin_prev;
  assign gate_rise = gate_q & ~gate_prev;
  assign gate_fall = ~gate_q & gate_prev;

  always_comb begin
    item_evt   = 1'b0;
    item_pat   = '0;
    item_stamp = ts_in;
    unique case (sel)
      SEL_FREE: begin
        item_evt = |free_hit;
        item_pat = free_hit;
      end
      SEL_GATED: begin
        item_evt   = gate_fall;
        item_pat   = acc;
        item_stamp = acc_stamp;
      end
      SEL_COIN: begin
        item_evt = |coin_hit;
        item_pat = coin_hit;
      end
      default: ;
    endcase
  end

  pts_hold #(.W(W), .TW(TW)) u_hold (
    .clk(clk), .rst_n(rst_n), .evt(item_evt), .pat_in(item_pat),
    .stamp_in(item_stamp), .ready(out_ready), .valid(out_valid),
    .pat(out_pattern), .stamp(out_stamp)
  );
endmodule

// File: rtl/pts_stage_chk.sv
`timescale 1ns/1ps
module pts_stage_chk #(
  parameter int W  = 16,
  parameter int TW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_pattern,
  input logic [TW-1:0] out_stamp,
  input logic [3:0]    cfg_mode,
  input logic [W-1:0]  cfg_enable,
  input logic          item_evt
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R11
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid); // R9
  AST_HOLD_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_stamp)); // R9
  AST_MERGE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> ((out_pattern & $past(out_pattern)) == $past(out_pattern))); // R9
  AST_EVT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    item_evt |=> out_valid); // R9
  AST_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode[2:0] == 3'b000 && !out_valid |=> !out_valid); // R10
  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && cfg_mode == 4'b0001 && $stable(cfg_mode) && $stable(cfg_enable)
    |-> (out_pattern & ~cfg_enable) == '0); // R1
endmodule

bind pts_stage pts_stage_chk #(.W(W), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_pattern(out_pattern), .out_stamp(out_stamp), .cfg_mode(cfg_mode),
  .cfg_enable(cfg_enable), .item_evt(item_evt)
);

// File: tb/pts_stage_test.sv
`timescale 1ns/1ps
module pts_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] grp_a_in = '0, grp_b_in = '0;
  logic        gate_in = 1'b0;
  logic [47:0] ts_in = 48'd1000;
  logic [15:0] cfg_enable = 16'hFFFF, cfg_invert = '0;
  logic [3:0]  cfg_mode = 4'b0001, cfg_stretch = '0;
  logic        cfg_free_gate = 1'b0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [15:0] out_pattern;
  logic [47:0] out_stamp;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  always @(posedge clk) ts_in <= ts_in + 48'd1;

  pts_stage uut (
    .clk(clk), .rst_n(rst_n), .grp_a_in(grp_a_in), .grp_b_in(grp_b_in),
    .gate_in(gate_in), .ts_in(ts_in), .cfg_enable(cfg_enable),
    .cfg_invert(cfg_invert), .cfg_mode(cfg_mode), .cfg_stretch(cfg_stretch),
    .cfg_free_gate(cfg_free_gate), .out_ready(out_ready),
    .out_valid(out_valid), .out_pattern(out_pattern), .out_stamp(out_stamp)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flush();
    out_ready = 1'b1;
    wait_n(4);
    out_ready = 1'b0;
  endtask

  task automatic expect_item(input string req, input logic [15:0] pat, input logic [47:0] st);
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " pattern"}, 64'(out_pattern), 64'(pat));
    check({req, " stamp"}, 64'(out_stamp), 64'(st));
  endtask

  task automatic t_reset();
    check("R11 reset valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    wait_n(2);
    check("R11 after reset", 64'(out_valid), 64'd0);
  endtask

  task automatic t_free();
    logic [47:0] v;
    cfg_mode = 4'b0001;
    @(negedge clk); grp_a_in = 16'h0005; v = ts_in;
    wait_n(2);
    expect_item("R3 free", 16'h0005, v + 48'd1);
    flush();
    wait_n(3);
    check("R3 held level no item", 64'(out_valid), 64'd0);
    grp_a_in = 16'h0000; wait_n(3);
  endtask

  task automatic t_mask();
    logic [47:0] v;
    cfg_enable = 16'hFFFE;
    @(negedge clk); grp_a_in = 16'h0003; v = ts_in;
    wait_n(2);
    expect_item("R1 mask", 16'h0002, v + 48'd1);
    grp_a_in = 16'h0000; flush();
    cfg_enable = 16'hFFFF; wait_n(2);
  endtask

  task automatic t_invert();
    logic [47:0] v;
    cfg_invert = 16'h0010; wait_n(2); flush();
    @(negedge clk); grp_a_in = 16'h0010;
    wait_n(3);
    check("R2 raw rise ignored", 64'(out_valid), 64'd0);
    @(negedge clk); grp_a_in = 16'h0000; v = ts_in;
    wait_n(2);
    expect_item("R2 raw fall", 16'h0010, v + 48'd1);
    flush();
    cfg_invert = 16'h0000; wait_n(2); flush();
  endtask

  task automatic t_free_gate();
    logic [47:0] v;
    cfg_free_gate = 1'b1;
    @(negedge clk); grp_a_in = 16'h0100;
    wait_n(3);
    check("R4 gate low blocks", 64'(out_valid), 64'd0);
    @(negedge clk); gate_in = 1'b1; v = ts_in;
    wait_n(2);
    expect_item("R4 gate rise", 16'h0100, v + 48'd1);
    gate_in = 1'b0; grp_a_in = 16'h0000; cfg_free_gate = 1'b0;
    flush();
  endtask

  task automatic t_gated();
    logic [47:0] v;
    cfg_mode = 4'b0010; wait_n(2);
    @(negedge clk); gate_in = 1'b1; v = ts_in;
    @(negedge clk); grp_a_in = 16'h0001;
    @(negedge clk); grp_a_in = 16'h0000;
    @(negedge clk); grp_a_in = 16'h0040;
    wait_n(2);
    check("R5 no item inside gate", 64'(out_valid), 64'd0);
    gate_in = 1'b0;
    wait_n(2);
    expect_item("R5 gated", 16'h0041, v + 48'd1);
    grp_a_in = 16'h0000; flush();
  endtask

  task automatic t_coin();
    logic [47:0] v;
    cfg_mode = 4'b0100; cfg_stretch = 4'd0; wait_n(2);
    @(negedge clk); grp_a_in = 16'h0002;
    wait_n(3);
    check("R6 A alone no item", 64'(out_valid), 64'd0);
    @(negedge clk); grp_b_in = 16'h0002; v = ts_in;
    wait_n(2);
    expect_item("R6 coincidence", 16'h0002, v + 48'd1);
    grp_a_in = '0; grp_b_in = '0; flush();
  endtask

  // A edge lands in cycle 1; second A edge at cycle a2; B high in cycles b1, b2
  task automatic stretch_run(input int a2, input int b1, input int b2, input int exp_n, input string req);
    int n = 0;
    grp_a_in = '0; grp_b_in = '0; out_ready = 1'b1;
    wait_n(20);
    for (int j = 0; j < 32; j++) begin
      @(negedge clk);
      if (out_valid) n++;
      grp_a_in = (j + 1 == 1 || j + 1 == a2) ? 16'h0008 : 16'h0000;
      grp_b_in = (j + 1 == b1 || j + 1 == b2) ? 16'h0008 : 16'h0000;
    end
    check(req, 64'(n), 64'(exp_n));
    out_ready = 1'b0;
  endtask

  task automatic t_stretch();
    cfg_mode = 4'b1100; cfg_stretch = 4'd2;
    stretch_run(0, 3, 6, 2, "R7 two B pulses on one stretched A");
    stretch_run(0, 10, 0, 1, "R8 B in last stretched cycle");
    stretch_run(0, 11, 0, 0, "R8 B one cycle past stretch");
    stretch_run(6, 15, 0, 1, "R8 retrigger extends stretch");
    cfg_stretch = 4'd0;
  endtask

  task automatic t_merge();
    logic [47:0] v;
    cfg_mode = 4'b0001; out_ready = 1'b0; wait_n(2);
    @(negedge clk); grp_a_in = 16'h0001; v = ts_in;
    wait_n(2);
    @(negedge clk); grp_a_in = 16'h0003;
    wait_n(3);
    expect_item("R9 merged hold", 16'h0003, v + 48'd1);
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
    check("R9 cleared on ready", 64'(out_valid), 64'd0);
    grp_a_in = '0; wait_n(2);
  endtask

  task automatic t_modes();
    cfg_mode = 4'b0000; wait_n(2);
    @(negedge clk); grp_a_in = 16'h0020;
    wait_n(3);
    check("R10 no mode no item", 64'(out_valid), 64'd0);
    grp_a_in = '0; wait_n(2);
    cfg_mode = 4'b0111; wait_n(2);
    @(negedge clk); grp_a_in = 16'h0010;
    wait_n(3);
    check("R10 coincidence has priority", 64'(out_valid), 64'd0);
    grp_a_in = '0; flush();
  endtask

  initial begin
    wait_n(3);
    t_reset();
    t_free();
    t_mask();
    t_invert();
    t_free_gate();
    t_gated();
    t_coin();
    t_stretch();
    t_merge();
    t_modes();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule